// File: doc/BRIEF.md
# Burst-Coalescing Completion Stager

This block stands between a producer of one-word completion descriptors and a circular completion queue held in host memory. Descriptors are collected in an eight-entry staging buffer and handed to a burst-write master in groups. A group is not sent until the buffer holds six entries. This cuts the number of separate bus transactions, because several completions travel together in one burst.

Before every burst, the block works out how many free slots the host queue has. It uses the host's read pointer and its own write pointer, and it keeps one slot empty so that a full queue can be told apart from an empty one. The burst is cut down to the free room. Entries that are not sent stay in order for a later attempt. If there is no room at all, an error pulse is raised and nothing is written. A control input turns the grouping off, and each descriptor then goes out as a burst of one beat. The host latches the done and error pulses into its own status bits.

Top module: `cmpl_burst_stager`

## Requirements
- R1: During and straight after reset, `m_valid`, `done_set` and `err_set` are 0 and `wr_ptr` is 0.
- R2: The free room is (2^QPTR_W − 1) − ((wr_ptr − host_rd_ptr) mod 2^QPTR_W). Each burst carries min(occupancy, room) beats in grouped mode.
- R3: With `fifo_en` = 1, no beat is issued while the buffer holds fewer than 6 descriptors.
- R4: A room check is made in an idle cycle. When it passes, the first beat appears in the next cycle. Beats then follow on consecutive cycles with data in arrival order, `m_addr` = `wr_ptr` + beat index (mod 2^QPTR_W), and `m_last` = 1 only on the final beat.
- R5: A room check that finds zero room gives a one-cycle `err_set` in the following cycle, issues no beat and leaves `wr_ptr` unchanged. No further check happens until a new descriptor is accepted or `host_rd_ptr` changes.
- R6: In the cycle after the final beat, `done_set` pulses for one cycle and `wr_ptr` has advanced by the burst length.
- R7: With `fifo_en` = 0, every descriptor is written as its own one-beat burst with `m_last` = 1. After each such burst a fresh check is made for any remaining entries.
- R8: A descriptor offered while the buffer holds 8 entries and no beat is leaving that cycle is discarded and never written. `err_set` pulses in the next cycle.
- R9: Descriptors left behind by a trimmed or refused burst keep their order and lead the next burst.
- R10: A room check is triggered by an accepted descriptor, by any change of `host_rd_ptr`, or by the end of a one-beat burst in ungrouped mode. A check is made only when occupancy has reached the threshold (6 when grouped, 1 when not).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: group descriptors up to the high-water mark; 0: send each alone |
| in_valid | input | 1 | Descriptor offered this cycle |
| in_data | input | DATA_W | Descriptor word |
| host_rd_ptr | input | QPTR_W | Host read index into the completion queue |
| m_valid | output | 1 | Burst beat valid |
| m_addr | output | QPTR_W | Queue slot written by this beat |
| m_data | output | DATA_W | Descriptor carried by this beat |
| m_last | output | 1 | Final beat of the burst |
| wr_ptr | output | QPTR_W | Local write index into the completion queue |
| done_set | output | 1 | One-cycle pulse after a completed burst |
| err_set | output | 1 | One-cycle pulse on no room or a discarded descriptor |

## Verification
A descriptor accepted at an edge that brings occupancy to the threshold is checked at the next edge, so its first beat is sampled at the second falling edge after the push. The completion pulse and the new write pointer are sampled one falling edge after the last beat. The bench samples exactly those falling edges for the high-water case. A zero-room check raises its error at the first falling edge after the check, and a discarded descriptor raises it at the falling edge right after its push. The bench sweeps the free room from 0 to 8 against a six-entry fill and computes each burst length, address and data word from the room formula. Where one-beat drains wait for the previous completion, the bench allows a short, bounded wait and then checks every beat in full.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } cbs_state_e;

endpackage

// File: rtl/cbs_store.sv
// Staging buffer: circular storage with occupancy count.
module cbs_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [DATA_W-1:0]                wdata,
  input  logic                             pop,
  output logic [DATA_W-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic                             full
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wr_idx, wr_idx_n;
  logic [IDX_W-1:0]  rd_idx, rd_idx_n;
  logic [CNT_W-1:0]  cnt_n;

  // one write-enabled word per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic we;
    assign we = push && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (we) begin
        mem[g] <= wdata;
      end
    end
  end

  always_comb begin
    wr_idx_n = wr_idx;
    rd_idx_n = rd_idx;
    cnt_n    = count;
    if (push) begin
      wr_idx_n = wr_idx + 1'b1;
    end
    if (pop) begin
      rd_idx_n = rd_idx + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_n = count + 1'b1;
      2'b01:   cnt_n = count - 1'b1;
      default: cnt_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      wr_idx <= wr_idx_n;
      rd_idx <= rd_idx_n;
      count  <= cnt_n;
    end
  end

  assign head = mem[rd_idx];
  assign full = (count == DEPTH_C);

endmodule

// File: rtl/cbs_room.sv
// Free-room calculation for the host queue and burst length selection.
module cbs_room #(
  parameter int QPTR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic [QPTR_W-1:0] wr_ptr,
  input  logic [QPTR_W-1:0] rd_ptr,
  input  logic [CNT_W-1:0]  count,
  input  logic              single,
  output logic [QPTR_W-1:0] room,
  output logic              no_room,
  output logic [CNT_W-1:0]  blen
);

  localparam logic [QPTR_W-1:0] QMAX = {QPTR_W{1'b1}};

  logic [QPTR_W-1:0] used;
  int                lim_i;
  int                room_i;

  always_comb begin
    used    = wr_ptr - rd_ptr;
    room    = QMAX - used;
    no_room = (room == '0);
    lim_i   = single ? 1 : int'(count);
    room_i  = int'(room);
    blen    = (lim_i < room_i) ? CNT_W'(lim_i) : CNT_W'(room_i);
  end

endmodule

// File: rtl/cbs_ctrl.sv
// Control: room-check arming, burst sequencing, write pointer, status pulses.
module cbs_ctrl
  import cbs_pkg::*;
#(
  parameter int QPTR_W = 4,
  parameter int CNT_W  = 4,
  parameter int HWM    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              in_valid,
  input  logic              full,
  input  logic [CNT_W-1:0]  count,
  input  logic              no_room,
  input  logic [CNT_W-1:0]  blen,
  input  logic [QPTR_W-1:0] host_rd_ptr,
  output logic              push,
  output logic              pop,
  output logic              beat_vld,
  output logic              beat_last,
  output logic [QPTR_W-1:0] beat_addr,
  output logic [QPTR_W-1:0] wr_ptr,
  output logic              done_set,
  output logic              err_set
);

  localparam logic [CNT_W-1:0] HWM_C = CNT_W'(HWM);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  cbs_state_e        state, state_n;
  logic [CNT_W-1:0]  beat, beat_n;
  logic [CNT_W-1:0]  len_q, len_n;
  logic [QPTR_W-1:0] wr_ptr_n;
  logic [QPTR_W-1:0] prev_rd;
  logic              armed, armed_n;
  logic              done_n, err_n;
  logic              chk, drop, rd_moved, end_beat;
  logic [CNT_W-1:0]  thr;

  always_comb begin
    pop       = (state == ST_BURST);
    push      = in_valid && !(full && !pop);
    drop      = in_valid && !push;
    thr       = fifo_en ? HWM_C : ONE_C;
    rd_moved  = (host_rd_ptr != prev_rd);
    chk       = (state == ST_IDLE) && armed && (count >= thr);
    end_beat  = (state == ST_BURST) && (beat == len_q - 1'b1);

    state_n  = state;
    beat_n   = beat;
    len_n    = len_q;
    wr_ptr_n = wr_ptr;
    done_n   = 1'b0;
    err_n    = drop;

    case (state)
      ST_IDLE: begin
        if (chk) begin
          if (no_room) begin
            err_n = 1'b1;
          end else begin
            state_n = ST_BURST;
            beat_n  = '0;
            len_n   = blen;
          end
        end
      end
      ST_BURST: begin
        beat_n = beat + 1'b1;
        if (end_beat) begin
          state_n  = ST_IDLE;
          wr_ptr_n = wr_ptr + QPTR_W'(len_q);
          done_n   = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase

    if (push || rd_moved || (end_beat && !fifo_en)) begin
      armed_n = 1'b1;
    end else if (chk) begin
      armed_n = 1'b0;
    end else begin
      armed_n = armed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat     <= '0;
      len_q    <= '0;
      wr_ptr   <= '0;
      prev_rd  <= '0;
      armed    <= 1'b0;
      done_set <= 1'b0;
      err_set  <= 1'b0;
    end else begin
      state    <= state_n;
      beat     <= beat_n;
      len_q    <= len_n;
      wr_ptr   <= wr_ptr_n;
      prev_rd  <= host_rd_ptr;
      armed    <= armed_n;
      done_set <= done_n;
      err_set  <= err_n;
    end
  end

  assign beat_vld  = (state == ST_BURST);
  assign beat_last = end_beat;
  assign beat_addr = wr_ptr + QPTR_W'(beat);

endmodule

// File: rtl/cmpl_burst_stager.sv
module cmpl_burst_stager #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int HWM    = 6,
  parameter int QPTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [QPTR_W-1:0] host_rd_ptr,
  output logic              m_valid,
  output logic [QPTR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic [QPTR_W-1:0] wr_ptr,
  output logic              done_set,
  output logic              err_set
);

  localparam int CNT_W = $clog2(DEPTH+1);

  logic             push, pop, full, no_room;
  logic [CNT_W-1:0] count, blen;
  logic [QPTR_W-1:0] room;
  logic [DATA_W-1:0] head;

  cbs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(in_data), .pop(pop),
    .head(head), .count(count), .full(full)
  );

  cbs_room #(.QPTR_W(QPTR_W), .CNT_W(CNT_W)) u_room (
    .wr_ptr(wr_ptr), .rd_ptr(host_rd_ptr), .count(count), .single(!fifo_en),
    .room(room), .no_room(no_room), .blen(blen)
  );

  cbs_ctrl #(.QPTR_W(QPTR_W), .CNT_W(CNT_W), .HWM(HWM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .in_valid(in_valid),
    .full(full), .count(count), .no_room(no_room), .blen(blen),
    .host_rd_ptr(host_rd_ptr), .push(push), .pop(pop),
    .beat_vld(m_valid), .beat_last(m_last), .beat_addr(m_addr),
    .wr_ptr(wr_ptr), .done_set(done_set), .err_set(err_set)
  );

  assign m_data = head;

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int QPTR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_en,
  input logic [QPTR_W-1:0] host_rd_ptr,
  input logic              m_valid,
  input logic [QPTR_W-1:0] m_addr,
  input logic              m_last,
  input logic [QPTR_W-1:0] wr_ptr,
  input logic              done_set
);

  // R4: the final beat closes the burst
  a_r4_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_last) |=> !m_valid);

  // R4: beats are back to back on rising slot addresses
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |=> (m_valid && (m_addr == QPTR_W'($past(m_addr) + 1'b1))));

  // R2: no beat may land in the slot that would make the queue look empty
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (QPTR_W'(m_addr + 1'b1) != host_rd_ptr));

  // R6: completion pulse only after a final beat
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |-> $past(m_valid && m_last));

  // R6: the write pointer moves only together with the completion pulse
  a_r6_ptr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_ptr) |-> done_set);

  // R7: a burst launched in ungrouped mode is one beat long
  a_r7_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(m_valid) && $past(!fifo_en)) |-> m_last);

endmodule

bind cmpl_burst_stager cbs_checker #(.QPTR_W(QPTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .host_rd_ptr(host_rd_ptr),
  .m_valid(m_valid), .m_addr(m_addr), .m_last(m_last), .wr_ptr(wr_ptr),
  .done_set(done_set)
);

// File: tb/sim_cmpl_burst_stager.sv
`timescale 1ns/1ps
module sim_cmpl_burst_stager;

  localparam int DW = 32;
  localparam int QW = 4;

  logic          clk;
  logic          rst_n;
  logic          fifo_en;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic [QW-1:0] host_rd_ptr;
  logic          m_valid;
  logic [QW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic          m_last;
  logic [QW-1:0] wr_ptr;
  logic          done_set;
  logic          err_set;

  int            checks;
  int            failures;
  logic [QW-1:0] exp_wr;
  logic [DW-1:0] next_data;
  logic [DW-1:0] oldest;

  cmpl_burst_stager #(.DATA_W(DW), .DEPTH(8), .HWM(6), .QPTR_W(QW)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .in_valid(in_valid),
    .in_data(in_data), .host_rd_ptr(host_rd_ptr), .m_valid(m_valid),
    .m_addr(m_addr), .m_data(m_data), .m_last(m_last), .wr_ptr(wr_ptr),
    .done_set(done_set), .err_set(err_set)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_one();
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = next_data;
    next_data = next_data + 1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_rd(input logic [QW-1:0] v);
    @(negedge clk);
    host_rd_ptr = v;
  endtask

  task automatic expect_burst(input int n, input int wait_max, input string req);
    int k;
    @(negedge clk);
    k = 1;
    while (!m_valid && k < wait_max) begin
      @(negedge clk);
      k++;
    end
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk(m_valid == 1'b1, {req, " beat valid"}, m_valid, 1);
      chk(m_data == oldest + DW'(i), {req, " data order"}, m_data, oldest + DW'(i));
      chk(m_addr == QW'(exp_wr + QW'(i)), {req, " R4 address"}, m_addr, QW'(exp_wr + QW'(i)));
      chk(m_last == (i == n - 1), {req, " R4 last flag"}, m_last, (i == n - 1));
    end
    @(negedge clk);
    chk(done_set == 1'b1, "R6 done pulse", done_set, 1);
    chk(m_valid == 1'b0, "R4 burst length", m_valid, 0);
    chk(wr_ptr == QW'(exp_wr + QW'(n)), "R6 pointer advance", wr_ptr, QW'(exp_wr + QW'(n)));
    exp_wr = QW'(exp_wr + QW'(n));
    oldest = oldest + DW'(n);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks      = 0;
    failures    = 0;
    rst_n       = 1'b0;
    fifo_en     = 1'b1;
    in_valid    = 1'b0;
    in_data     = '0;
    host_rd_ptr = '0;
    exp_wr      = '0;
    next_data   = 32'hA000_0000;
    oldest      = 32'hA000_0000;

    repeat (3) @(negedge clk);
    chk(m_valid == 1'b0 && done_set == 1'b0 && err_set == 1'b0, "R1 outputs in reset", m_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ptr == '0, "R1 wr_ptr after reset", wr_ptr, 0);
    chk(m_valid == 1'b0 && err_set == 1'b0, "R1 quiet after reset", m_valid, 0);

    // R3: five descriptors stay staged
    for (int i = 0; i < 5; i++) push_one();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(m_valid == 1'b0, "R3 held below high-water", m_valid, 0);
    end
    push_one();
    expect_burst(6, 1, "R4 high-water burst");

    // R2 / R5 / R9 / R7 sweep of the free room against a six-entry fill
    for (int r = 0; r <= 8; r++) begin
      int sent;
      set_rd(QW'(exp_wr + 4'd1 + QW'(r)));
      repeat (2) @(negedge clk);
      for (int i = 0; i < 6; i++) push_one();
      if (r == 0) begin
        @(negedge clk);
        chk(err_set == 1'b1, "R5 no-room error", err_set, 1);
        chk(m_valid == 1'b0, "R5 no beat", m_valid, 0);
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          chk(err_set == 1'b0 && m_valid == 1'b0, "R5 no repeat check", err_set, 0);
        end
        chk(wr_ptr == exp_wr, "R5 pointer kept", wr_ptr, exp_wr);
        set_rd(exp_wr);
        expect_burst(6, 3, "R9 R10 retry after refusal");
      end else begin
        sent = (r < 6) ? r : 6;
        expect_burst(sent, 1, "R2 trimmed burst");
        if (sent < 6) begin
          @(negedge clk);
          fifo_en = 1'b0;
          set_rd(exp_wr);
          for (int j = 0; j < 6 - sent; j++) begin
            expect_burst(1, 4, "R7 R9 leftover single");
          end
          @(negedge clk);
          fifo_en = 1'b1;
        end
      end
    end

    // R7: ungrouped mode sends a lone descriptor at once
    @(negedge clk);
    fifo_en = 1'b0;
    set_rd(exp_wr);
    push_one();
    expect_burst(1, 1, "R7 immediate single");
    @(negedge clk);
    fifo_en = 1'b1;

    // R8: discard when full
    set_rd(QW'(exp_wr + 4'd1));
    for (int i = 0; i < 8; i++) push_one();
    push_one();
    chk(err_set == 1'b1, "R8 discard error", err_set, 1);
    push_one();
    chk(err_set == 1'b1, "R8 second discard error", err_set, 1);
    set_rd(exp_wr);
    expect_burst(8, 3, "R8 stored entries only");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(m_valid == 1'b0, "R8 discarded never written", m_valid, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule